// File: doc/BRIEF.md
# Pointer-Counter Byte Transfer Channel

This block is one direction of a simple peripheral DMA engine. It moves single bytes between a serial peripheral's data register and system memory. Software loads a memory address into the pointer and a byte count into the counter. From then on, each ready strobe from the peripheral starts exactly one memory access. In a transmit instance that access is a memory read whose byte is handed to the peripheral. In a receive instance the peripheral's byte is written to memory. Each completed access advances the pointer by one and lowers the counter by one.

When the counter reaches zero the channel raises its end flag, which can also drive an interrupt. It then ignores the peripheral until software writes a new nonzero count. Only one memory access is outstanding at a time. A ready strobe that arrives during an access is remembered and served as soon as that access completes.

Top module: `pdcChannel`

## Requirements
- R1: After reset the pointer and counter read 0, the end flag is low, no memory request is pending and periphDone is low.
- R2: With a nonzero count and no register write in the same cycle, a periphReady pulse raises memReq on the following clock edge with memAddr equal to the pointer; memWe is 1 in a receive instance (IS_TX=0) and 0 in a transmit instance (IS_TX=1).
- R3: While memReq is high and memAck is low, memReq stays high and memAddr stays unchanged.
- R4: The clock edge that samples memReq and memAck both high ends the access: memReq falls, the counter drops by one, the pointer rises by one (wrapping at its width), and periphDone is high for exactly the one following cycle.
- R5: A transmit instance presents on periphWData the memRData byte sampled with memAck; a receive instance presents on memWData the periphRData byte sampled in the cycle its request was issued.
- R6: The access that takes the counter from 1 to 0 sets endFlag; irq equals endFlag AND irqEnable.
- R7: While the counter is 0, periphReady pulses start no memory request.
- R8: Writing a nonzero count clears endFlag and re-arms the channel; writing zero leaves endFlag unchanged.
- R9: periphReady pulses seen while an access is in flight are merged into one pending request, served in the cycle after periphDone; the pending request is dropped if the finishing access brings the counter to 0.
- R10: Pointer and count writes are ignored while an access is in flight; a periphReady pulse in the same cycle as an accepted write is held and served once the write has taken effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrWrEn | input | 1 | Load the pointer from ptrWrData |
| ptrWrData | input | ADDR_W | New pointer value |
| cntWrEn | input | 1 | Load the counter from cntWrData |
| cntWrData | input | CNT_W | New count value |
| irqEnable | input | 1 | Enables end flag onto irq |
| periphReady | input | 1 | Peripheral ready strobe |
| periphRData | input | 8 | Peripheral received byte (receive instance) |
| periphWData | output | 8 | Byte for the peripheral (transmit instance) |
| periphDone | output | 1 | One-cycle pulse per completed transfer |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | 8 | Byte written to memory (receive instance) |
| memRData | input | 8 | Byte read from memory |
| memAck | input | 1 | Memory access complete |
| ptrValue | output | ADDR_W | Current pointer |
| cntValue | output | CNT_W | Current counter |
| endFlag | output | 1 | End-of-buffer status |
| irq | output | 1 | Interrupt request |

## Verification
Buffers of one to four bytes are swept against memory latencies of zero to three wait cycles. Address and data checks after each step separate an off-by-one in the pointer or counter from a lost or duplicated request. The memory answers each read with a byte derived from its address, so a stale or misaligned transmit byte shows up at once. A receive instance repeats the sweep with a changing peripheral byte to confirm the write direction and the capture point. Extra strobes during an access, strobes at zero count, and writes made during an access or together with a strobe tell the merge and drop rules apart from plain pacing.

// File: rtl/pdcTypes.sv
package pdcTypes;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadPtr;
    logic loadCnt;
    logic issue;    // a memory access starts this cycle
    logic finish;   // the outstanding access completes this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/pdcControl.sv
module pdcControl
  import pdcTypes::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ptrWrEn,
  input  logic         cntWrEn,
  input  logic         periphReady,
  input  logic         memAck,
  input  logic         cntZero,
  input  logic         cntOne,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         doneQ
);
  logic pending;
  logic wantXfer;
  logic anyWrite;

  assign anyWrite = (ptrWrEn || cntWrEn) && !busy;
  assign wantXfer = periphReady || pending;

  always_comb begin
    strobes.loadPtr = ptrWrEn && !busy;
    strobes.loadCnt = cntWrEn && !busy;
    strobes.issue   = !busy && wantXfer && !cntZero && !anyWrite;
    strobes.finish  = busy && memAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      pending <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobes.finish;
      if (strobes.issue)       busy <= 1'b1;
      else if (strobes.finish) busy <= 1'b0;

      if (strobes.issue)
        pending <= 1'b0;
      else if (strobes.finish && cntOne)
        pending <= 1'b0;
      else if (!busy && cntZero && !strobes.loadCnt)
        pending <= 1'b0;
      else
        pending <= wantXfer;
    end
  end
endmodule

// File: rtl/pdcDatapath.sv
module pdcDatapath
  import pdcTypes::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter bit IS_TX  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic [7:0]        periphRData,
  input  logic [7:0]        memRData,
  output logic [ADDR_W-1:0] ptrQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic [7:0]        dataQ,
  output logic              endQ,
  output logic              cntZero,
  output logic              cntOne
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assign cntZero = (cntQ == '0);
  assign cntOne  = (cntQ == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
      cntQ <= '0;
      endQ <= 1'b0;
    end else begin
      if (strobes.loadPtr) ptrQ <= ptrWrData;
      else if (strobes.finish) ptrQ <= ptrQ + ADDR_W'(1);

      if (strobes.loadCnt) begin
        cntQ <= cntWrData;
        if (cntWrData != '0) endQ <= 1'b0;
      end else if (strobes.finish) begin
        cntQ <= cntQ - CNT_ONE;
        if (cntOne) endQ <= 1'b1;
      end
    end
  end

  generate
    if (IS_TX) begin : gTxData
      always_ff @(posedge clk) begin
        if (!rstN) dataQ <= '0;
        else if (strobes.finish) dataQ <= memRData;
      end
    end else begin : gRxData
      always_ff @(posedge clk) begin
        if (!rstN) dataQ <= '0;
        else if (strobes.issue) dataQ <= periphRData;
      end
    end
  endgenerate
endmodule

// File: rtl/pdcChannel.sv
module pdcChannel
  import pdcTypes::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter bit IS_TX  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              irqEnable,
  input  logic              periphReady,
  input  logic [7:0]        periphRData,
  output logic [7:0]        periphWData,
  output logic              periphDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWData,
  input  logic [7:0]        memRData,
  input  logic              memAck,
  output logic [ADDR_W-1:0] ptrValue,
  output logic [CNT_W-1:0]  cntValue,
  output logic              endFlag,
  output logic              irq
);
  ctrlStrobes_t strobes;
  logic busy, cntZero, cntOne;
  logic [7:0] dataQ;

  pdcControl uCtrl (
    .clk(clk), .rstN(rstN), .ptrWrEn(ptrWrEn), .cntWrEn(cntWrEn),
    .periphReady(periphReady), .memAck(memAck), .cntZero(cntZero),
    .cntOne(cntOne), .strobes(strobes), .busy(busy), .doneQ(periphDone)
  );

  pdcDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IS_TX(IS_TX)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ptrWrData(ptrWrData),
    .cntWrData(cntWrData), .periphRData(periphRData), .memRData(memRData),
    .ptrQ(ptrValue), .cntQ(cntValue), .dataQ(dataQ), .endQ(endFlag),
    .cntZero(cntZero), .cntOne(cntOne)
  );

  assign memReq      = busy;
  assign memWe       = !IS_TX;
  assign memAddr     = ptrValue;
  assign memWData    = dataQ;
  assign periphWData = dataQ;
  assign irq         = endFlag && irqEnable;
endmodule

// File: rtl/pdcChannelChecker.sv
module pdcChannelChecker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] ptrValue,
  input logic [CNT_W-1:0]  cntValue,
  input logic              endFlag,
  input logic              periphDone
);
  assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  assert_step_counts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (!memReq && periphDone
      && cntValue == CNT_W'($past(cntValue) - CNT_W'(1))
      && ptrValue == ADDR_W'($past(ptrValue) + ADDR_W'(1))));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    periphDone |=> !periphDone);

  assert_end_on_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> (periphDone && cntValue == '0));

  assert_idle_at_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cntValue == '0 && !memReq) |=> !memReq);
endmodule

bind pdcChannel pdcChannelChecker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memAddr(memAddr),
  .ptrValue(ptrValue), .cntValue(cntValue), .endFlag(endFlag),
  .periphDone(periphDone)
);

// File: tb/pdcChannel_test.sv
module pdcChannel_test;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int nRun = 0, nFail = 0;

  // transmit instance signals
  logic ptrWrEn = 0, cntWrEn = 0, irqEnable = 0, periphReady = 0, memAck = 0;
  logic [AW-1:0] ptrWrData = '0;
  logic [CW-1:0] cntWrData = '0;
  logic [7:0] periphRData = '0;
  logic [7:0] periphWData, memWData, memRData;
  logic periphDone, memReq, memWe, endFlag, irq;
  logic [AW-1:0] memAddr, ptrValue;
  logic [CW-1:0] cntValue;

  assign memRData = memAddr[7:0] ^ 8'h5A;

  pdcChannel #(.ADDR_W(AW), .CNT_W(CW), .IS_TX(1'b1)) uut (
    .clk(clk), .rstN(rstN), .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .irqEnable(irqEnable),
    .periphReady(periphReady), .periphRData(periphRData),
    .periphWData(periphWData), .periphDone(periphDone), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck), .ptrValue(ptrValue),
    .cntValue(cntValue), .endFlag(endFlag), .irq(irq)
  );

  // receive instance signals
  logic rPtrWrEn = 0, rCntWrEn = 0, rReady = 0, rAck = 0;
  logic [AW-1:0] rPtrWrData = '0;
  logic [CW-1:0] rCntWrData = '0;
  logic [7:0] rPData = '0;
  logic [7:0] rPWData, rMWData;
  logic rDone, rReq, rWe, rEnd, rIrq;
  logic [AW-1:0] rAddr, rPtr;
  logic [CW-1:0] rCnt;

  pdcChannel #(.ADDR_W(AW), .CNT_W(CW), .IS_TX(1'b0)) uutRx (
    .clk(clk), .rstN(rstN), .ptrWrEn(rPtrWrEn), .ptrWrData(rPtrWrData),
    .cntWrEn(rCntWrEn), .cntWrData(rCntWrData), .irqEnable(1'b1),
    .periphReady(rReady), .periphRData(rPData),
    .periphWData(rPWData), .periphDone(rDone), .memReq(rReq),
    .memWe(rWe), .memAddr(rAddr), .memWData(rMWData),
    .memRData(8'h00), .memAck(rAck), .ptrValue(rPtr),
    .cntValue(rCnt), .endFlag(rEnd), .irq(rIrq)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic writeRegs(input logic [AW-1:0] p, input logic [CW-1:0] c, input logic pulse);
    ptrWrEn = 1; ptrWrData = p; cntWrEn = 1; cntWrData = c; periphReady = pulse;
    tick();
    ptrWrEn = 0; cntWrEn = 0; periphReady = 0;
  endtask

  // one full transmit transfer with lat wait cycles; caller ensures idle & count nonzero
  task automatic txOne(input logic [AW-1:0] expPtr, input logic [CW-1:0] expCnt, input int lat);
    periphReady = 1; tick(); periphReady = 0;
    check("R2", "memReq after ready", memReq, 1);
    check("R2", "memAddr", memAddr, expPtr);
    check("R2", "memWe tx", memWe, 0);
    for (int i = 0; i < lat; i++) begin
      tick();
      check("R3", "memReq held", memReq, 1);
      check("R3", "memAddr held", memAddr, expPtr);
    end
    memAck = 1; tick(); memAck = 0;
    check("R4", "memReq falls", memReq, 0);
    check("R4", "periphDone", periphDone, 1);
    check("R4", "counter", cntValue, CW'(expCnt - 1));
    check("R4", "pointer", ptrValue, AW'(expPtr + 1));
    check("R5", "tx byte", periphWData, expPtr[7:0] ^ 8'h5A);
    tick();
    check("R4", "periphDone single", periphDone, 0);
  endtask

  initial begin
    repeat (2) tick();
    check("R1", "ptr", ptrValue, 0);
    check("R1", "cnt", cntValue, 0);
    check("R1", "end", endFlag, 0);
    check("R1", "req", memReq, 0);
    check("R1", "done", periphDone, 0);
    rstN = 1; tick();

    // R7: ready at zero count
    periphReady = 1; tick(); periphReady = 0; tick();
    check("R7", "no req at zero", memReq, 0);

    // sweep buffer length x latency; base includes wrap at top of address space
    for (int n = 1; n <= 4; n++) begin
      for (int lat = 0; lat <= 3; lat++) begin
        logic [AW-1:0] base;
        base = (lat == 3) ? AW'(16'hFFFE) : AW'(n * 37 + lat * 5);
        writeRegs(base, CW'(n), 0);
        check("R8", "end cleared by load", endFlag, 0);
        for (int k = 0; k < n; k++)
          txOne(AW'(base + k), CW'(n - k), lat);
        check("R6", "end set", endFlag, 1);
        irqEnable = 0; #1;
        check("R6", "irq masked", irq, 0);
        irqEnable = 1; #1;
        check("R6", "irq on", irq, 1);
        periphReady = 1; tick(); periphReady = 0; tick();
        check("R7", "ignored after end", memReq, 0);
        check("R7", "count stays", cntValue, 0);
      end
    end

    // R8: zero write leaves flag
    cntWrEn = 1; cntWrData = 0; tick(); cntWrEn = 0;
    check("R8", "zero write keeps end", endFlag, 1);

    // R9: merged pending strobes
    writeRegs(16'h0100, 8'd3, 0);
    periphReady = 1; tick();
    check("R9", "first req", memReq, 1);
    tick(); periphReady = 0; tick(); periphReady = 1; tick(); periphReady = 0;
    memAck = 1; tick(); memAck = 0;
    check("R9", "done", periphDone, 1);
    check("R9", "req low in done cycle", memReq, 0);
    tick();
    check("R9", "pending served", memReq, 1);
    check("R9", "pending addr", memAddr, 16'h0101);
    memAck = 1; tick(); memAck = 0; tick(); tick();
    check("R9", "merged into one", memReq, 0);
    check("R9", "count", cntValue, 1);

    // R10: write during busy ignored
    periphReady = 1; tick(); periphReady = 0;
    cntWrEn = 1; cntWrData = 8'd9; ptrWrEn = 1; ptrWrData = 16'h7777; tick();
    cntWrEn = 0; ptrWrEn = 0;
    check("R10", "cnt unchanged while busy", cntValue, 1);
    check("R10", "ptr unchanged while busy", ptrValue, 16'h0102);
    // R9 drop: pending strobe while final access
    periphReady = 1; tick(); periphReady = 0;
    memAck = 1; tick(); memAck = 0;
    check("R6", "end after final", endFlag, 1);
    tick(); tick();
    check("R9", "pending dropped at zero", memReq, 0);

    // R10: ready together with write is held
    writeRegs(16'h0200, 8'd2, 1);
    check("R10", "no req on write cycle", memReq, 0);
    check("R10", "count loaded", cntValue, 2);
    tick();
    check("R10", "held strobe served", memReq, 1);
    check("R10", "served addr", memAddr, 16'h0200);
    memAck = 1; tick(); memAck = 0; tick();

    // receive instance sweep
    check("R2", "rx memWe", rWe, 1);
    rPtrWrEn = 1; rPtrWrData = 16'h0040; rCntWrEn = 1; rCntWrData = 8'd4; tick();
    rPtrWrEn = 0; rCntWrEn = 0;
    for (int k = 0; k < 4; k++) begin
      rPData = 8'(8'hC3 + k * 17); rReady = 1; tick(); rReady = 0;
      rPData = 8'hEE;
      check("R2", "rx req", rReq, 1);
      check("R2", "rx addr", rAddr, 16'h0040 + k);
      check("R5", "rx byte", rMWData, 8'(8'hC3 + k * 17));
      for (int i = 0; i < k; i++) tick();
      check("R3", "rx held", rReq, 1);
      rAck = 1; tick(); rAck = 0;
      check("R4", "rx done", rDone, 1);
      check("R4", "rx cnt", rCnt, 3 - k);
      tick();
    end
    check("R6", "rx end", rEnd, 1);
    check("R6", "rx irq", rIrq, 1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule